// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block collects a wide vector of single-cycle event pulses into five 16-bit secondary status banks. Each bank has its own mask register. Every source belongs to one functional group. A group's bit in a read-only primary summary register is set while any of its sources is pending and not masked. The summary has its own mask. A single active-low interrupt pin is asserted while any unmasked summary bit is set, and a configuration bit chooses whether that pin is push-pull or open-drain.

Software reaches every register through a simple synchronous port with separate write and read strobes and a registered read result. The interrupt handler reads the summary first. It reads only the banks whose groups are flagged, then acknowledges events by writing the value it read back to the status bank (write-one-to-clear). The two touch events each own a dedicated summary bit, so their handler can skip the secondary read entirely.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status bits are 0, all five bank masks and the summary mask are 0xFFFF, the config register is 0, and the pin is idle: `irq_pin_o`=1 with `irq_oe_o`=1.
- R2: A 1 on `ev_i[16*b+i]` in a cycle sets status bit i of bank b at that clock edge, whether or not the bit is masked. The bit stays set until software clears it.
- R3: Writing a status bank clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Summary bit g is 1 exactly when some source of group g has status 1 and bank mask bit 0. The group map is: bank0 bit0→0, bank0 bit1→1, bank0 bits2–5→2, bank0 bits6–7→3, bank0 bits8–15→4, bank1 bits0–7→5, bank1 bits8–15→6, bank2 all→7, bank3 bits0–7→7, bank3 bits8–15→8, bank4 all→9. Summary bits 10–15 read 0.
- R6: The touch pen-down source (bank0 bit0) and the touch data source (bank0 bit1) appear alone on summary bits 0 and 1.
- R7: The interrupt is active while (summary AND NOT summary-mask) is nonzero. A summary-mask bit of 1 blocks its group, so writing 0 enables every group.
- R8: Clearing a mask bit over a pending status bit asserts the pin in the cycle right after the write edge, with no further delay.
- R9: With config bit0 = 0 the pin is push-pull: `irq_oe_o`=1 and `irq_pin_o` = NOT active. With config bit0 = 1 it is open-drain: `irq_pin_o`=0 and `irq_oe_o` = active.
- R10: A read strobe at one clock edge presents the addressed register on `rdata_o` after that edge, and `rdata_o` holds its value while no read is requested. Unmapped addresses read 0. Writes to the summary or to unmapped addresses change nothing.
- R11: Word address map: 0 summary (read-only), 1 summary mask, 2 config (bit0 = open-drain), 3+b status of bank b, 8+b mask of bank b (b = 0..4), 13–15 unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_i | input | 80 | Event pulses, bit 16*b+i feeds bank b bit i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_pin_o | output | 1 | Interrupt pin drive value (active low) |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
Some properties are checked on every cycle: that events always land in status, that no status bit falls without a matching clear, and that the pin drive agrees with summary and summary mask in both driver modes. Summary bits outside the group range must stay at zero, and a summary bit can only be set while some status bit is set. Other behaviour can only be shown by the directed scenarios. These cover the exact group of each source, the collision of an event with a clear, the cycle in which unmasking takes effect, the read latency, and writes to read-only or unmapped addresses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned NUM_BANKS  = 5;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned ADDR_W     = 4;

  // word addresses
  localparam int unsigned A_SUM      = 0;
  localparam int unsigned A_SUM_MASK = 1;
  localparam int unsigned A_CFG      = 2;
  localparam int unsigned A_STAT0    = 3;
  localparam int unsigned A_MASK0    = A_STAT0 + NUM_BANKS;

  // summary group indices
  localparam int unsigned G_PEN   = 0;
  localparam int unsigned G_TDATA = 1;
  localparam int unsigned G_ADC   = 2;
  localparam int unsigned G_TMR   = 3;
  localparam int unsigned G_SYS   = 4;
  localparam int unsigned G_CHG   = 5;
  localparam int unsigned G_CUR   = 6;
  localparam int unsigned G_UV    = 7;
  localparam int unsigned G_HC    = 8;
  localparam int unsigned G_GPIO  = 9;
  localparam int unsigned NUM_GROUPS = 10;

  // group that source bit i of bank b rolls up into
  function automatic int unsigned grp_of(int unsigned b, int unsigned i);
    int unsigned g;
    case (b)
      0: begin
        if (i == 0)      g = G_PEN;
        else if (i == 1) g = G_TDATA;
        else if (i <= 5) g = G_ADC;
        else if (i <= 7) g = G_TMR;
        else             g = G_SYS;
      end
      1:       g = (i < 8) ? G_CHG : G_CUR;
      2:       g = G_UV;
      3:       g = (i < 8) ? G_UV : G_HC;
      default: g = G_GPIO;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ev_i,
  input  logic         stat_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] clr_o
);

  logic [W-1:0] stat_q, mask_q;

  // bits acknowledged by this cycle's write
  assign clr_o = stat_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q & ~clr_o) | ev_i;   // new event wins over clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = stat_q & ~mask_q;

endmodule

// File: rtl/irq_group_map.sv
module irq_group_map
  import irq_agg_pkg::*;
#(
  parameter int unsigned NB = 5,
  parameter int unsigned W  = 16
) (
  input  logic [NB*W-1:0] pend_i,
  output logic [W-1:0]    sum_o
);

  localparam int unsigned GW = $clog2(W);

  always_comb begin
    logic [GW-1:0] g;
    sum_o = '0;
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < W; i++) begin
        g = GW'(grp_of(b, i));
        if (pend_i[b*W+i]) sum_o[g] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_out_drv.sv
module irq_out_drv (
  input  logic od_mode_i,
  input  logic active_i,
  output logic pin_o,
  output logic oe_o
);

  always_comb begin
    if (od_mode_i) begin
      pin_o = 1'b0;
      oe_o  = active_i;
    end else begin
      pin_o = ~active_i;
      oe_o  = 1'b1;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NB = irq_agg_pkg::NUM_BANKS,
  parameter int unsigned W  = irq_agg_pkg::REG_W,
  parameter int unsigned AW = irq_agg_pkg::ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB*W-1:0] ev_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic          irq_pin_o,
  output logic          irq_oe_o
);

  logic [NB*W-1:0] stat_flat, mask_flat, pend_flat, clr_flat;
  logic [W-1:0]    sum_w;
  logic [W-1:0]    sum_mask_q;
  logic            od_mode_q;
  logic            irq_active;
  logic [W-1:0]    rd_mux;
  logic [W-1:0]    rdata_q;

  // secondary banks
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic stat_we, mask_we;
    assign stat_we = wr_en_i && (addr_i == AW'(A_STAT0 + b));
    assign mask_we = wr_en_i && (addr_i == AW'(A_MASK0 + b));

    irq_status_bank #(.W(W)) bank_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ev_i      (ev_i[b*W +: W]),
      .stat_we_i (stat_we),
      .mask_we_i (mask_we),
      .wdata_i   (wdata_i),
      .stat_o    (stat_flat[b*W +: W]),
      .mask_o    (mask_flat[b*W +: W]),
      .pend_o    (pend_flat[b*W +: W]),
      .clr_o     (clr_flat[b*W +: W])
    );
  end

  irq_group_map #(.NB(NB), .W(W)) map_i (
    .pend_i (pend_flat),
    .sum_o  (sum_w)
  );

  // summary mask and configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_mask_q <= '1;
      od_mode_q  <= 1'b0;
    end else if (wr_en_i) begin
      if (addr_i == AW'(A_SUM_MASK)) sum_mask_q <= wdata_i;
      if (addr_i == AW'(A_CFG))      od_mode_q  <= wdata_i[0];
    end
  end

  assign irq_active = |(sum_w & ~sum_mask_q);

  irq_out_drv drv_i (
    .od_mode_i (od_mode_q),
    .active_i  (irq_active),
    .pin_o     (irq_pin_o),
    .oe_o      (irq_oe_o)
  );

  // read mux and registered read data
  always_comb begin
    rd_mux = '0;
    if (addr_i == AW'(A_SUM))      rd_mux = sum_w;
    if (addr_i == AW'(A_SUM_MASK)) rd_mux = sum_mask_q;
    if (addr_i == AW'(A_CFG))      rd_mux = W'(od_mode_q);
    for (int b = 0; b < NB; b++) begin
      if (addr_i == AW'(A_STAT0 + b)) rd_mux = stat_flat[b*W +: W];
      if (addr_i == AW'(A_MASK0 + b)) rd_mux = mask_flat[b*W +: W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned NB = 5,
  parameter int unsigned W  = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NB*W-1:0] ev_i,
  input logic [NB*W-1:0] stat_flat,
  input logic [NB*W-1:0] clr_flat,
  input logic [W-1:0]  sum_w,
  input logic [W-1:0]  sum_mask_q,
  input logic          od_mode_q,
  input logic          irq_pin_o,
  input logic          irq_oe_o
);

  localparam logic [W-1:0] USED = W'((64'd1 << NUM_GROUPS) - 64'd1);

  AST_EVENT_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev_i) |=> ((stat_flat & $past(ev_i)) == $past(ev_i))); // R2

  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(stat_flat) & ~stat_flat) & ~$past(clr_flat)) == '0)); // R3

  AST_PUSH_PULL_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !od_mode_q |-> (irq_oe_o && (irq_pin_o == ((sum_w & ~sum_mask_q) == '0)))); // R9

  AST_OPEN_DRAIN_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_mode_q |-> (!irq_pin_o && (irq_oe_o == ((sum_w & ~sum_mask_q) != '0)))); // R9

  AST_UNUSED_SUM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_w & ~USED) == '0); // R5

  AST_SUM_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sum_w) |-> (|stat_flat)); // R5

endmodule

bind irq_aggregator irq_aggregator_chk #(.NB(NB), .W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_i       (ev_i),
  .stat_flat  (stat_flat),
  .clr_flat   (clr_flat),
  .sum_w      (sum_w),
  .sum_mask_q (sum_mask_q),
  .od_mode_q  (od_mode_q),
  .irq_pin_o  (irq_pin_o),
  .irq_oe_o   (irq_oe_o)
);

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB*W-1:0] ev = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          pin, oe;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ev_i(ev), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_pin_o(pin), .irq_oe_o(oe)
  );

  // group of flat source index n = 16*bank + bit, per the R5 map
  function automatic int exp_group(int n);
    if (n < 1)  return 0;
    if (n < 2)  return 1;
    if (n < 6)  return 2;
    if (n < 8)  return 3;
    if (n < 16) return 4;
    if (n < 24) return 5;
    if (n < 32) return 6;
    if (n < 56) return 7;
    if (n < 64) return 8;
    return 9;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_write(int a, logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(int a, output logic [W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(int n);
    @(negedge clk); ev[n] = 1'b1;
    @(negedge clk); ev[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    check("R1 pin", W'(pin), 16'h1);
    check("R1 oe", W'(oe), 16'h1);
    reg_read(0, d); check("R1 summary", d, 16'h0);
    reg_read(1, d); check("R1 summary mask", d, 16'hFFFF);
    reg_read(2, d); check("R1 config", d, 16'h0);
    for (int b = 0; b < NB; b++) begin
      reg_read(3 + b, d); check("R1 status", d, 16'h0);
      reg_read(8 + b, d); check("R1 bank mask", d, 16'hFFFF);
    end
  endtask

  task automatic t_latch_unmask_clear();
    logic [W-1:0] d;
    pulse(2*16 + 5);
    reg_read(5, d); check("R2 masked event latched", d, 16'h0020);
    reg_read(0, d); check("R5 masked source hidden", d, 16'h0);
    check("R2 pin idle while masked", W'(pin), 16'h1);
    reg_write(10, 16'hFFDF);
    reg_read(0, d); check("R5 bank2 to group 7", d, 16'h0080);
    check("R7 summary mask blocks", W'(pin), 16'h1);
    reg_write(1, 16'h0000);
    check("R8 pin asserted next cycle", W'(pin), 16'h0);
    reg_write(5, 16'h0000);
    reg_read(5, d); check("R3 zero write keeps", d, 16'h0020);
    check("R7 still active", W'(pin), 16'h0);
    reg_write(5, 16'h0020);
    check("R3 pin released after clear", W'(pin), 16'h1);
    reg_read(5, d); check("R3 cleared", d, 16'h0);
    reg_write(10, 16'hFFFF);
    reg_write(1, 16'hFFFF);
  endtask

  task automatic t_collide();
    logic [W-1:0] d;
    pulse(16 + 3);
    pulse(16 + 4);
    @(negedge clk);
    ev[16 + 3] = 1'b1; wr_en = 1'b1; addr = 4'd4; wdata = 16'h0018;
    @(negedge clk);
    ev[16 + 3] = 1'b0; wr_en = 1'b0;
    reg_read(4, d); check("R4 event beats clear", d, 16'h0008);
    reg_write(4, 16'h0008);
    reg_read(4, d); check("R3 bank1 cleared", d, 16'h0);
  endtask

  task automatic t_touch();
    logic [W-1:0] d;
    reg_write(8, 16'hFFFC);
    pulse(0);
    reg_read(0, d); check("R6 pen-down bit", d, 16'h0001);
    pulse(1);
    reg_read(0, d); check("R6 touch data bit", d, 16'h0003);
    reg_write(3, 16'h0003);
    reg_read(0, d); check("R6 touch cleared", d, 16'h0);
    reg_write(8, 16'hFFFF);
  endtask

  task automatic t_groups();
    logic [W-1:0] d;
    for (int b = 0; b < NB; b++) reg_write(8 + b, 16'h0000);
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 6; k++) begin
        int i;
        case (k)
          0: i = 0;  1: i = 1;  2: i = 4;
          3: i = 7;  4: i = 8;  default: i = 15;
        endcase
        pulse(b*16 + i);
        reg_read(0, d);
        check("R5 group map", d, W'(1) << exp_group(b*16 + i));
        reg_write(3 + b, W'(1) << i);
        reg_read(0, d); check("R5 group cleared", d, 16'h0);
      end
    end
  endtask

  task automatic t_open_drain();
    reg_write(2, 16'h0001);
    check("R9 od idle oe", W'(oe), 16'h0);
    check("R9 od idle pin", W'(pin), 16'h0);
    reg_write(1, 16'h0000);
    pulse(4*16 + 3);
    check("R9 od active oe", W'(oe), 16'h1);
    check("R9 od active pin", W'(pin), 16'h0);
    reg_write(7, 16'h0008);
    check("R9 od released", W'(oe), 16'h0);
    reg_write(2, 16'h0000);
    check("R9 push-pull pin", W'(pin), 16'h1);
    check("R9 push-pull oe", W'(oe), 16'h1);
    reg_write(1, 16'hFFFF);
  endtask

  task automatic t_regmap();
    logic [W-1:0] d;
    reg_write(0, 16'hFFFF);
    reg_read(0, d); check("R10 summary write ignored", d, 16'h0);
    reg_write(14, 16'hABCD);
    reg_read(14, d); check("R10 unmapped reads zero", d, 16'h0);
    reg_write(1, 16'h1234);
    @(negedge clk); rd_en = 1'b1; addr = 4'd1;
    check("R10 data before edge", rdata, 16'h0);
    @(negedge clk); rd_en = 1'b0;
    check("R10 data after one edge", rdata, 16'h1234);
    addr = 4'd2;
    @(negedge clk);
    check("R10 data held without read", rdata, 16'h1234);
    reg_read(11, d); check("R11 bank3 mask address", d, 16'h0000);
    reg_write(1, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch_unmask_clear();
    t_collide();
    t_touch();
    t_groups();
    t_open_drain();
    t_regmap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule